// File: doc/BRIEF.md
# Approximate Unsigned Multiplier with Windowed Error Recovery

This block multiplies two unsigned operands for error-tolerant datapaths such as filtering or image blending, where a slightly low product is acceptable in exchange for a shallow logic tree. It forms one AND-gate row per bit of the second operand and reduces the rows pairwise in a balanced binary tree. Each node of the tree is a carry-limited adder: a carry moves at most one bit position. Every node also reports the value it failed to propagate as an error vector.

The block does not sum all the error vectors exactly. It ORs them bit by bit, keeps only a window of the upper product bits that the parameter `RECOV_K` selects, and adds that one merged vector to the tree output with a single exact adder. With a small `RECOV_K` the hardware is cheaper and the result less exact. With a large `RECOV_K` most of the loss is recovered. The block has no clock. The product is a combinational function of the operands.

Top module: `approx_mult_recover`

## Requirements
- R1: The product is 2·OP_W bits wide and is a combinational function of the two OP_W-bit operands. Partial-product row j equals opA when bit j of opB is 1, and zero otherwise, shifted left by j.
- R2: Each tree adder computes, for every bit p, sum[p] = (x[p] XOR y[p]) OR (x[p-1] AND y[p-1]) and err[p] = (x[p] XOR y[p]) AND (x[p-1] AND y[p-1]), where the term for bit -1 is 0. The integer sum + err equals x + y.
- R3: The tree has log2(OP_W) layers and OP_W-1 adders. The first layer pairs rows (0,1), (2,3) and so on, and each later layer pairs adjacent results of the layer below in the same way.
- R4: The error vectors of all adders are merged by bitwise OR. Only bits 2·OP_W-2 down to 2·OP_W-1-RECOV_K survive. Merged bits below that window, and the top product bit, are forced to zero.
- R5: The output equals the tree sum plus the masked merged error vector, added exactly once, after the last tree layer.
- R6: With RECOV_K = 0, the output equals the raw tree sum.
- R7: For every operand pair, the output is at most opA·opB and the final addition never carries out of 2·OP_W bits.
- R8: A zero operand gives a zero product. An operand equal to 1 gives the other operand exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | OP_W | Multiplicand, unsigned |
| opB | input | OP_W | Multiplier, unsigned; bit j enables partial-product row j |
| product | output | 2*OP_W | Approximate product after windowed error recovery |

## Verification
The hardest case to reach from the ports is an error bit that sits exactly at the lower edge of the recovery window. Such a bit is kept when it falls one place higher and dropped when it falls one place lower.

The stimulus reaches this case by giving opB only its two top bits. This isolates a single first-layer adder and lets the bench slide a known carry collision to bit 10 or bit 12 by choosing opA. In that arrangement every other adder adds zero and stays exact.

Colliding error bits in the OR merge, which lose value, come only from denser operands. An exhaustive sweep over all operand pairs covers those cases. The sweep runs against three instances whose windows are empty, mid-sized and full.

// File: rtl/approx_mult_pkg.sv
package approx_mult_pkg;

  // Index of the first node of tree level lvl in a flat node array whose
  // leaves (level 0) occupy indices 0 .. nLeaves-1.
  function automatic int levelBase(input int nLeaves, input int lvl);
    return 2 * nLeaves - ((2 * nLeaves) >> lvl);
  endfunction

  // True when product bit pos lies inside the recovery window.
  function automatic bit inWindow(input int prodW, input int recovK, input int pos);
    return (pos <= prodW - 2) && (pos >= prodW - 1 - recovK);
  endfunction

endpackage

// File: rtl/approx_pp_gen.sv
module approx_pp_gen #(
  parameter int OP_W   = 8,
  parameter int PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]              opA,
  input  logic [OP_W-1:0]              opB,
  output logic [OP_W-1:0][PROD_W-1:0]  ppRows
);

  // R1: one gated, shifted copy of opA per bit of opB
  for (genvar j = 0; j < OP_W; j++) begin : g_row
    logic [PROD_W-1:0] rowExt;
    assign rowExt    = {{(PROD_W-OP_W){1'b0}}, opA & {OP_W{opB[j]}}};
    assign ppRows[j] = rowExt << j;
  end

endmodule

// File: rtl/approx_add_row.sv
module approx_add_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] errOut
);

  logic [W-1:0] propVec;
  logic [W-1:0] genVec;
  logic [W-1:0] genUp;

  // R2: a generate only reaches the next bit; the collision is reported
  assign propVec = addA ^ addB;
  assign genVec  = addA & addB;
  assign genUp   = {genVec[W-2:0], 1'b0};
  assign sumOut  = propVec | genUp;
  assign errOut  = propVec & genUp;

  always_comb begin
    AST_SPLIT_EXACT: assert (({1'b0, sumOut} + {1'b0, errOut}) == ({1'b0, addA} + {1'b0, addB})); // R2
    AST_ERR_UNDER_SUM: assert ((errOut & ~sumOut) == '0); // R2
  end

endmodule

// File: rtl/approx_tree.sv
module approx_tree
  import approx_mult_pkg::*;
#(
  parameter int OP_W     = 8,
  parameter int PROD_W   = 2 * OP_W,
  parameter int N_ADDERS = OP_W - 1
) (
  input  logic [OP_W-1:0][PROD_W-1:0]     ppRows,
  output logic [PROD_W-1:0]               treeSum,
  output logic [N_ADDERS-1:0][PROD_W-1:0] errVecs
);

  localparam int LEVELS = $clog2(OP_W);
  localparam int NODES  = 2 * OP_W - 1;

  if ((1 << LEVELS) != OP_W || OP_W < 2) begin : g_bad_width
    $error("approx_tree: OP_W must be a power of two, at least 2");
  end

  logic [PROD_W-1:0] nodeVal [NODES];

  for (genvar j = 0; j < OP_W; j++) begin : g_leaf
    assign nodeVal[j] = ppRows[j];
  end

  // R3: level lv node ix sums nodes 2*ix and 2*ix+1 of level lv-1
  for (genvar lv = 1; lv <= LEVELS; lv++) begin : g_lvl
    for (genvar ix = 0; ix < (OP_W >> lv); ix++) begin : g_node
      localparam int SRC = levelBase(OP_W, lv - 1) + 2 * ix;
      localparam int DST = levelBase(OP_W, lv) + ix;
      approx_add_row #(.W(PROD_W)) u_add (
        .addA   (nodeVal[SRC]),
        .addB   (nodeVal[SRC+1]),
        .sumOut (nodeVal[DST]),
        .errOut (errVecs[DST-OP_W])
      );
    end
  end

  assign treeSum = nodeVal[NODES-1];

endmodule

// File: rtl/error_recover.sv
module error_recover
  import approx_mult_pkg::*;
#(
  parameter int PROD_W   = 16,
  parameter int N_ADDERS = 7,
  parameter int RECOV_K  = 4
) (
  input  logic [PROD_W-1:0]               treeSum,
  input  logic [N_ADDERS-1:0][PROD_W-1:0] errVecs,
  output logic [PROD_W-1:0]               product
);

  if (RECOV_K < 0 || RECOV_K > PROD_W - 1) begin : g_bad_k
    $error("error_recover: RECOV_K out of range");
  end

  logic [PROD_W-1:0] winMask;
  logic [PROD_W-1:0] orAll;
  logic [PROD_W-1:0] mergedErr;
  logic              carryOut;

  // R4: window mask computed per bit from the parameters
  for (genvar p = 0; p < PROD_W; p++) begin : g_mask
    assign winMask[p] = inWindow(PROD_W, RECOV_K, p);
  end

  // R4: bitwise OR stands in for a full error sum
  always_comb begin
    orAll = '0;
    for (int n = 0; n < N_ADDERS; n++) begin
      orAll = orAll | errVecs[n];
    end
  end

  assign mergedErr = orAll & winMask;

  // R5: single exact addition after the tree
  assign {carryOut, product} = {1'b0, treeSum} + {1'b0, mergedErr};

  always_comb begin
    AST_NO_OVERFLOW: assert (carryOut == 1'b0); // R7
    if (RECOV_K == 0) begin
      AST_RAW_WHEN_K0: assert (product == treeSum); // R6
    end
  end

endmodule

// File: rtl/approx_mult_recover.sv
module approx_mult_recover #(
  parameter int OP_W    = 8,
  parameter int RECOV_K = 4
) (
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product
);

  localparam int PROD_W   = 2 * OP_W;
  localparam int N_ADDERS = OP_W - 1;

  logic [OP_W-1:0][PROD_W-1:0]     ppRows;
  logic [PROD_W-1:0]               treeSum;
  logic [N_ADDERS-1:0][PROD_W-1:0] errVecs;

  approx_pp_gen #(.OP_W(OP_W), .PROD_W(PROD_W)) u_pp (
    .opA    (opA),
    .opB    (opB),
    .ppRows (ppRows)
  );

  approx_tree #(.OP_W(OP_W), .PROD_W(PROD_W), .N_ADDERS(N_ADDERS)) u_tree (
    .ppRows  (ppRows),
    .treeSum (treeSum),
    .errVecs (errVecs)
  );

  error_recover #(.PROD_W(PROD_W), .N_ADDERS(N_ADDERS), .RECOV_K(RECOV_K)) u_rec (
    .treeSum (treeSum),
    .errVecs (errVecs),
    .product (product)
  );

  logic [PROD_W-1:0] exactProd;
  assign exactProd = PROD_W'(opA) * PROD_W'(opB);

  always_comb begin
    AST_BOUNDED: assert (product <= exactProd); // R7
    AST_ZERO_IN: assert (!(opA == '0 || opB == '0) || product == '0); // R8
  end

endmodule

// File: tb/tb_approx_mult_recover.sv
module tb_approx_mult_recover;

  logic clk = 1'b0;
  logic rstN;
  logic [7:0] opA, opB;
  logic [15:0] prodMid, prodRaw, prodFull;
  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;

  always #5 clk = ~clk;

  approx_mult_recover #(.OP_W(8), .RECOV_K(4))  dut     (.opA(opA), .opB(opB), .product(prodMid));
  approx_mult_recover #(.OP_W(8), .RECOV_K(0))  dutRaw  (.opA(opA), .opB(opB), .product(prodRaw));
  approx_mult_recover #(.OP_W(8), .RECOV_K(15)) dutFull (.opA(opA), .opB(opB), .product(prodFull));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
  endtask

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 150000) begin
      failCount = failCount + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycleCount);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s a=%0d b=%0d: actual %0d expected %0d", req, opA, opB, act, exp);
    end
  endtask

  task automatic checkLe(input string req, input logic [15:0] act, input logic [15:0] lim);
    checkCount++;
    if (act > lim) begin
      failCount++;
      $display("FAIL %s a=%0d b=%0d: actual %0d expected <= %0d", req, opA, opB, act, lim);
    end
  endtask

  // Carry-limited add from R2
  function automatic void refAdd(input logic [15:0] x, input logic [15:0] y,
                                 output logic [15:0] s, output logic [15:0] e);
    for (int p = 0; p < 16; p++) begin
      logic prevG, pr;
      prevG = (p > 0) ? (x[p-1] & y[p-1]) : 1'b0;
      pr    = x[p] ^ y[p];
      s[p]  = pr | prevG;
      e[p]  = pr & prevG;
    end
  endfunction

  // Expected product from R1, R3, R4, R5
  function automatic logic [15:0] refProduct(input logic [7:0] a, input logic [7:0] b, input int k);
    logic [15:0] lvl [8];
    logic [15:0] errOr, s, e, masked;
    int cnt;
    for (int j = 0; j < 8; j++) lvl[j] = b[j] ? (16'(a) << j) : 16'h0;
    errOr = '0;
    cnt = 8;
    while (cnt > 1) begin
      for (int i = 0; i < cnt / 2; i++) begin
        refAdd(lvl[2*i], lvl[2*i+1], s, e);
        lvl[i] = s;
        errOr |= e;
      end
      cnt = cnt / 2;
    end
    masked = '0;
    for (int p = 0; p < 16; p++) if (p <= 14 && p >= 15 - k) masked[p] = errOr[p];
    return lvl[0] + masked;
  endfunction

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    #1;
    opA = a;
    opB = b;
    @(negedge clk);
  endtask

  task automatic testReset();
    opA = '0; opB = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset zero", prodMid, 16'd0);
    rstN = 1'b1;
  endtask

  task automatic testZeroOne();
    apply(8'd0, 8'd213);   check("R8 zero a", prodFull, 16'd0);
    apply(8'd177, 8'd0);   check("R8 zero b", prodMid, 16'd0);
    apply(8'd1, 8'd183);   check("R8 one a", prodRaw, 16'd183);
    apply(8'd255, 8'd1);   check("R8 one b", prodRaw, 16'd255);
  endtask

  // Only row 0 and row 1 are non-zero: the single adder collides at bit 4.
  task automatic testSingleCell();
    apply(8'h0F, 8'h03);
    check("R2 raw cell sum", prodRaw, 16'd29);
    check("R4 low error dropped k=4", prodMid, 16'd29);
    check("R5 full recovery", prodFull, 16'd45);
  endtask

  // Rows 6 and 7 only: the collision lands at bit 10 (just below the k=4
  // window) or at bit 12 (inside it).
  task automatic testWindowEdge();
    apply(8'h0F, 8'hC0);
    check("R6 raw tree k=0", prodRaw, 16'd1856);
    check("R4 bit10 outside window", prodMid, 16'd1856);
    check("R4 bit10 kept k=15", prodFull, 16'd2880);
    apply(8'h3C, 8'hC0);
    check("R6 raw tree k=0", prodRaw, 16'd7424);
    check("R4 bit12 inside window", prodMid, 16'd11520);
  endtask

  task automatic testExhaustive();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        logic [15:0] exact;
        apply(8'(a), 8'(b));
        exact = 16'(a) * 16'(b);
        check("R1 R3 R5 model k=4", prodMid, refProduct(8'(a), 8'(b), 4));
        check("R6 model k=0", prodRaw, refProduct(8'(a), 8'(b), 0));
        check("R4 model k=15", prodFull, refProduct(8'(a), 8'(b), 15));
        checkLe("R7 bound k=4", prodMid, exact);
        checkLe("R7 bound k=15", prodFull, exact);
      end
    end
  endtask

  initial begin
    testReset();
    testZeroOne();
    testSingleCell();
    testWindowEdge();
    testExhaustive();
    summary();
    $finish;
  end

endmodule